// File: doc/BRIEF.md
# Hash Binning Sorter Engine

This block files a stream of data items into a fixed set of key bins so that a consumer can later fetch the items grouped by bin without running a comparison sort. Each incoming item has a numeric key (for example the slope of a track segment), an ID and a payload. The bin is taken from the upper bits of the key, so each bin covers one contiguous key range. While items arrive, the block does two things per bin. It counts them, as a histogram would. It also links each new item to the previous one in the same bin through a next-slot table. Each item lands in the next free slot of a data store, in arrival order.

A write costs one storage access, so one item can be accepted every clock. Items leave the block through a single output stream at one item per clock. A bin query returns the items of one bin in arrival order. A dump walks every bin in ascending order. A clear command sweeps the bin table one bin per clock and signals when the sweep is done.

The control is a five-state machine.
- `S_IDLE` accepts writes and commands. It goes to `S_CLEAR` on a clear, or to `S_SCAN` on a query or dump.
- `S_SCAN` inspects the current bin. It goes to `S_WALK` if the bin holds items. For a dump it moves to the next bin if the bin is empty and later bins hold items. Otherwise it emits an empty beat and returns to `S_IDLE`.
- `S_WALK` emits one item per clock along the chain. After the last item of the bin it goes to `S_SCAN` (dump with more occupied bins above) or to `S_IDLE`.
- `S_CLEAR` zeroes one bin count per clock and goes to `S_CDONE` after the top bin.
- `S_CDONE` raises the done pulse for one clock and returns to `S_IDLE`.

Top module: `hash_binning_sorter`

## Requirements
- R1: With default parameters, an item's bin is bits [11:8] of its 12-bit key. Keys above `KEY_MAX` (default 0xFF0) are first saturated to `KEY_MAX`, so every key maps to one of the 16 bins.
- R2: `wr_ready` is high exactly when the block is idle, the store holds fewer than 64 items and no command input is high. An item is taken on every clock where `wr_valid` and `wr_ready` are both high, so back-to-back items are accepted on consecutive clocks.
- R3: Once a walk of a bin starts, that bin's items appear on consecutive clocks, one per clock.
- R4: A query of a non-empty bin emits exactly that bin's items in arrival order. Every beat carries `out_bin` equal to the bin and `out_count` equal to the bin's item count. `out_last` is high on the final beat only, and `out_empty` is low on every beat.
- R5: A query of an empty bin emits a single beat with `out_empty`=1, `out_last`=1, `out_count`=0 and `out_bin` equal to the requested bin.
- R6: A dump emits every stored item exactly once, with bins in ascending order and arrival order within each bin, and `out_last` only on the very last item. An empty store yields a single beat with `out_empty`=1 and `out_last`=1.
- R7: After 64 accepted items `wr_ready` stays low. A write attempt (`wr_valid` high) while the store is full sets `overflow`, which stays high until a clear.
- R8: When a clear is requested, `clear_done` pulses high for one clock, 17 clocks after the request edge. The request edge is the first; the sixteen sweep clocks follow. After the clear every bin is empty, the store is empty and `overflow` is low.
- R9: Items written to the same bin on consecutive clocks are all chained, and a later query returns each of them.
- R10: After reset, `wr_ready`=1, `out_valid`=0, `overflow`=0, `clear_done`=0 and every bin is empty.
- R11: While a query, dump or clear is in progress, `wr_ready` is low. An item presented then is not stored, and later read-outs do not contain it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Item offered on the write port |
| wr_ready | output | 1 | Block can take an item this clock |
| wr_key | input | 12 | Sort key of the item |
| wr_id | input | 8 | Item ID |
| wr_payload | input | 16 | Item payload |
| clear_req | input | 1 | Start a clear sweep (sampled when idle) |
| clear_done | output | 1 | One-clock pulse when the sweep has finished |
| query_req | input | 1 | Read out one bin (sampled when idle) |
| query_bin | input | 4 | Bin to read on a query |
| dump_req | input | 1 | Read out all bins (sampled when idle) |
| out_valid | output | 1 | Read-out beat present |
| out_empty | output | 1 | Beat carries no item (empty bin or empty store) |
| out_last | output | 1 | Final beat of this read-out |
| out_bin | output | 4 | Bin of this beat |
| out_count | output | 7 | Item count of that bin |
| out_id | output | 8 | Item ID |
| out_payload | output | 16 | Item payload |
| overflow | output | 1 | Sticky: write attempted while full |

## Verification
A wrong count or end pointer shows up on the next query of the affected bin. The query then emits too few or too many beats, or an item from the wrong slot, and `out_count` disagrees with the number of beats. A broken next-slot link shows up as items that are wrong or out of order partway through a bin's walk. These errors appear only when the bin is read back, so every write phase is followed by queries of several bins and by a full dump. Mistakes in the dump's move from one bin to the next show up as a missing, repeated or misplaced bin group, or as a misplaced last flag.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_WALK,
        S_CLEAR,
        S_CDONE
    } hbs_state_e;
endpackage

// File: rtl/hbs_bin_table.sv
module hbs_bin_table #(
    parameter int NBINS  = 16,
    parameter int BIN_W  = 4,
    parameter int SLOT_W = 6,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              app_en,
    input  logic [BIN_W-1:0]  app_bin,
    input  logic [SLOT_W-1:0] app_slot,
    output logic [CNT_W-1:0]  app_count,
    output logic [SLOT_W-1:0] app_end,
    input  logic              clr_en,
    input  logic [BIN_W-1:0]  clr_bin,
    input  logic [BIN_W-1:0]  look_bin,
    output logic [CNT_W-1:0]  look_count,
    output logic [SLOT_W-1:0] look_begin,
    output logic [NBINS-1:0]  nonempty
);
    logic [CNT_W-1:0]  count_q [NBINS];
    logic [SLOT_W-1:0] begin_q [NBINS];
    logic [SLOT_W-1:0] end_q   [NBINS];

    assign app_count  = count_q[app_bin];
    assign app_end    = end_q[app_bin];
    assign look_count = count_q[look_bin];
    assign look_begin = begin_q[look_bin];

    for (genvar g = 0; g < NBINS; g++) begin : g_occ
        assign nonempty[g] = (count_q[g] != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBINS; i++) begin
                count_q[i] <= '0;
            end
        end else if (clr_en) begin
            count_q[clr_bin] <= '0;
        end else if (app_en) begin
            count_q[app_bin] <= count_q[app_bin] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (app_en) begin
            if (count_q[app_bin] == '0) begin
                begin_q[app_bin] <= app_slot;
            end
            end_q[app_bin] <= app_slot;
        end
    end

    // R9: every append grows its bin by exactly one
    a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (app_en && !clr_en) |=> (count_q[$past(app_bin)] == $past(app_count) + CNT_W'(1)));
endmodule

// File: rtl/hbs_item_store.sv
module hbs_item_store #(
    parameter int DEPTH  = 64,
    parameter int SLOT_W = 6,
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              link_en,
    input  logic [SLOT_W-1:0] link_from,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [DATA_W-1:0] rd_data,
    output logic [SLOT_W-1:0] rd_next
);
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [SLOT_W-1:0] next_q [DEPTH];

    assign rd_data = data_q[rd_slot];
    assign rd_next = next_q[rd_slot];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_q[wr_slot] <= wr_data;
        end
        if (link_en) begin
            next_q[link_from] <= wr_slot;
        end
    end

    // R9: a link is only made alongside a store, and never points at itself
    a_r9_link_fresh: assert property (@(posedge clk) disable iff (!rst_n)
        link_en |-> (wr_en && (link_from != wr_slot)));
endmodule

// File: rtl/hash_binning_sorter.sv
module hash_binning_sorter #(
    parameter int KEY_W    = 12,
    parameter int BIN_BITS = 4,
    parameter int ID_W     = 8,
    parameter int PAY_W    = 16,
    parameter int DEPTH    = 64,
    parameter logic [KEY_W-1:0] KEY_MAX = 12'hFF0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_valid,
    output logic                 wr_ready,
    input  logic [KEY_W-1:0]     wr_key,
    input  logic [ID_W-1:0]      wr_id,
    input  logic [PAY_W-1:0]     wr_payload,
    input  logic                 clear_req,
    output logic                 clear_done,
    input  logic                 query_req,
    input  logic [BIN_BITS-1:0]  query_bin,
    input  logic                 dump_req,
    output logic                 out_valid,
    output logic                 out_empty,
    output logic                 out_last,
    output logic [BIN_BITS-1:0]  out_bin,
    output logic [$clog2(DEPTH):0] out_count,
    output logic [ID_W-1:0]      out_id,
    output logic [PAY_W-1:0]     out_payload,
    output logic                 overflow
);
    import hbs_pkg::*;

    localparam int NBINS  = 1 << BIN_BITS;
    localparam int SLOT_W = $clog2(DEPTH);
    localparam int CNT_W  = SLOT_W + 1;
    localparam int DATA_W = ID_W + PAY_W;

    hbs_state_e         state_q, state_d;
    logic [BIN_BITS-1:0] cur_q, cur_d;
    logic [SLOT_W-1:0]  ptr_q, ptr_d;
    logic [CNT_W-1:0]   remain_q, remain_d;
    logic               dump_q, dump_d;
    logic [CNT_W-1:0]   fill_q, fill_d;
    logic               ovf_q, ovf_d;

    logic               idle, full, cmd_any, wr_fire, link_en, clr_en;
    logic [KEY_W-1:0]   key_sat;
    logic [BIN_BITS-1:0] wr_bin;
    logic [CNT_W-1:0]   app_count, look_count;
    logic [SLOT_W-1:0]  app_end, look_begin, rd_next;
    logic [DATA_W-1:0]  rd_data;
    logic [NBINS-1:0]   nonempty, above;
    logic               more_above;

    assign idle     = (state_q == S_IDLE);
    assign full     = (fill_q == CNT_W'(DEPTH));
    assign cmd_any  = clear_req | query_req | dump_req;
    assign wr_ready = idle && !full && !cmd_any;
    assign wr_fire  = wr_valid && wr_ready;
    assign key_sat  = (wr_key > KEY_MAX) ? KEY_MAX : wr_key;
    assign wr_bin   = key_sat[KEY_W-1 -: BIN_BITS];
    assign link_en  = wr_fire && (app_count != '0);
    assign overflow = ovf_q;

    for (genvar g = 0; g < NBINS; g++) begin : g_above
        assign above[g] = nonempty[g] && (BIN_BITS'(g) > cur_q);
    end
    assign more_above = |above;

    hbs_bin_table #(
        .NBINS(NBINS), .BIN_W(BIN_BITS), .SLOT_W(SLOT_W), .CNT_W(CNT_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n),
        .app_en(wr_fire), .app_bin(wr_bin), .app_slot(fill_q[SLOT_W-1:0]),
        .app_count(app_count), .app_end(app_end),
        .clr_en(clr_en), .clr_bin(cur_q),
        .look_bin(cur_q), .look_count(look_count), .look_begin(look_begin),
        .nonempty(nonempty)
    );

    hbs_item_store #(
        .DEPTH(DEPTH), .SLOT_W(SLOT_W), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_fire), .wr_slot(fill_q[SLOT_W-1:0]), .wr_data({wr_id, wr_payload}),
        .link_en(link_en), .link_from(app_end),
        .rd_slot(ptr_q), .rd_data(rd_data), .rd_next(rd_next)
    );

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            cur_q    <= '0;
            ptr_q    <= '0;
            remain_q <= '0;
            dump_q   <= 1'b0;
            fill_q   <= '0;
            ovf_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            cur_q    <= cur_d;
            ptr_q    <= ptr_d;
            remain_q <= remain_d;
            dump_q   <= dump_d;
            fill_q   <= fill_d;
            ovf_q    <= ovf_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d  = state_q;
        cur_d    = cur_q;
        ptr_d    = ptr_q;
        remain_d = remain_q;
        dump_d   = dump_q;
        fill_d   = fill_q + CNT_W'(wr_fire);
        ovf_d    = ovf_q | (wr_valid && full);
        unique case (state_q)
            S_IDLE: begin
                if (clear_req) begin
                    state_d = S_CLEAR;
                    cur_d   = '0;
                    fill_d  = '0;
                    ovf_d   = 1'b0;
                end else if (query_req) begin
                    state_d = S_SCAN;
                    cur_d   = query_bin;
                    dump_d  = 1'b0;
                end else if (dump_req) begin
                    state_d = S_SCAN;
                    cur_d   = '0;
                    dump_d  = 1'b1;
                end
            end
            S_SCAN: begin
                if (look_count != '0) begin
                    state_d  = S_WALK;
                    ptr_d    = look_begin;
                    remain_d = look_count;
                end else if (!dump_q || !more_above) begin
                    state_d = S_IDLE;
                end else begin
                    cur_d = cur_q + BIN_BITS'(1);
                end
            end
            S_WALK: begin
                ptr_d    = rd_next;
                remain_d = remain_q - CNT_W'(1);
                if (remain_q == CNT_W'(1)) begin
                    if (dump_q && more_above) begin
                        state_d = S_SCAN;
                        cur_d   = cur_q + BIN_BITS'(1);
                    end else begin
                        state_d = S_IDLE;
                    end
                end
            end
            S_CLEAR: begin
                cur_d = cur_q + BIN_BITS'(1);
                if (cur_q == BIN_BITS'(NBINS - 1)) begin
                    state_d = S_CDONE;
                end
            end
            S_CDONE: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // output logic
    always_comb begin
        out_valid   = 1'b0;
        out_empty   = 1'b0;
        out_last    = 1'b0;
        out_bin     = cur_q;
        out_count   = look_count;
        out_id      = rd_data[DATA_W-1 -: ID_W];
        out_payload = rd_data[PAY_W-1:0];
        clear_done  = 1'b0;
        clr_en      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_SCAN: begin
                if (look_count == '0 && (!dump_q || !more_above)) begin
                    out_valid   = 1'b1;
                    out_empty   = 1'b1;
                    out_last    = 1'b1;
                    out_id      = '0;
                    out_payload = '0;
                end
            end
            S_WALK: begin
                out_valid = 1'b1;
                out_last  = (remain_q == CNT_W'(1)) && !(dump_q && more_above);
            end
            S_CLEAR: clr_en = 1'b1;
            S_CDONE: clear_done = 1'b1;
            default: ;
        endcase
    end

    // R3: a bin walk with items left keeps emitting on the next clock
    a_r3_walk_continuous: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WALK && remain_q > CNT_W'(1)) |=> (state_q == S_WALK && out_valid));

    // R7: overflow holds until a clear is taken
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(idle && clear_req)) |=> ovf_q);

    // R7: the store never holds more items than slots
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH));

    // R8: done is a single-clock pulse followed by idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        clear_done |=> (!clear_done && idle));

    // R5: an empty beat is final and reports zero items
    a_r5_empty_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_empty) |-> (out_last && out_count == '0));
endmodule

// File: tb/tb_hash_binning_sorter.sv
`timescale 1ns/1ps
module tb_hash_binning_sorter;
    localparam int NB = 16;
    localparam int DEP = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [11:0] wr_key = '0;
    logic [7:0]  wr_id = '0;
    logic [15:0] wr_payload = '0;
    logic        clear_req = 1'b0;
    logic        clear_done;
    logic        query_req = 1'b0;
    logic [3:0]  query_bin = '0;
    logic        dump_req = 1'b0;
    logic        out_valid, out_empty, out_last, overflow;
    logic [3:0]  out_bin;
    logic [6:0]  out_count;
    logic [7:0]  out_id;
    logic [15:0] out_payload;

    hash_binning_sorter dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_key(wr_key),
        .wr_id(wr_id), .wr_payload(wr_payload),
        .clear_req(clear_req), .clear_done(clear_done),
        .query_req(query_req), .query_bin(query_bin), .dump_req(dump_req),
        .out_valid(out_valid), .out_empty(out_empty), .out_last(out_last),
        .out_bin(out_bin), .out_count(out_count), .out_id(out_id),
        .out_payload(out_payload), .overflow(overflow)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 1'b0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [23:0] mq [NB][$];
    int          n_stored = 0;

    int          b_bin[$];
    int          b_cnt[$];
    int          b_cyc[$];
    logic [23:0] b_dat[$];
    bit          b_emp[$];
    bit          b_last[$];
    bit          busy_ready_seen;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bin_of(input logic [11:0] k);
        logic [11:0] s;
        s = (k > 12'hFF0) ? 12'hFF0 : k;
        return int'(s[11:8]);
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        finish_run();
    end

    // one write beat; leaves wr_valid high, caller drops it
    task automatic put(input logic [11:0] k, input logic [7:0] id, input logic [15:0] p);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_key = k;
        wr_id = id;
        wr_payload = p;
        #1;
        if (wr_ready) begin
            mq[bin_of(k)].push_back({id, p});
            n_stored++;
        end
        @(posedge clk);
    endtask

    task automatic drop();
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // issue query (is_dump=0) or dump, gather beats; wr_valid held high meanwhile (R11)
    task automatic collect(input bit is_dump, input int bin);
        int guard;
        b_bin.delete(); b_cnt.delete(); b_cyc.delete();
        b_dat.delete(); b_emp.delete(); b_last.delete();
        busy_ready_seen = 1'b0;
        @(negedge clk);
        if (is_dump) dump_req = 1'b1;
        else begin
            query_req = 1'b1;
            query_bin = 4'(bin);
        end
        @(negedge clk);
        dump_req = 1'b0;
        query_req = 1'b0;
        wr_valid = 1'b1;
        wr_key = 12'(urand_key());
        wr_id = 8'hEE;
        wr_payload = 16'hDEAD;
        guard = 0;
        while (guard < 400) begin
            #1;
            if (wr_ready) busy_ready_seen = 1'b1;
            if (out_valid) begin
                b_bin.push_back(int'(out_bin));
                b_cnt.push_back(int'(out_count));
                b_cyc.push_back(cyc);
                b_dat.push_back({out_id, out_payload});
                b_emp.push_back(out_empty);
                b_last.push_back(out_last);
                if (out_last) break;
            end
            @(negedge clk);
            guard++;
        end
        wr_valid = 1'b0;
        chk(!busy_ready_seen, "R11", "wr_ready low while reading out", busy_ready_seen, 0);
    endtask

    function automatic int urand_key();
        return int'($urandom_range(0, 4095));
    endfunction

    task automatic check_query(input int bin);
        int n;
        collect(1'b0, bin);
        n = mq[bin].size();
        if (n == 0) begin
            chk(b_bin.size() == 1, "R5", "empty query beat count", b_bin.size(), 1);
            if (b_bin.size() == 1) begin
                chk(b_emp[0] && b_last[0], "R5", "empty beat flags", {b_emp[0], b_last[0]}, 2'b11);
                chk(b_cnt[0] == 0, "R5", "empty beat count", b_cnt[0], 0);
                chk(b_bin[0] == bin, "R5", "empty beat bin", b_bin[0], bin);
            end
        end else begin
            chk(b_bin.size() == n, "R4", "query beat count", b_bin.size(), n);
            for (int i = 0; i < n && i < b_bin.size(); i++) begin
                chk(b_dat[i] == mq[bin][i], "R4", "query item/order (R1 R9)", b_dat[i], mq[bin][i]);
                chk(b_bin[i] == bin && b_cnt[i] == n, "R4", "query bin/count",
                    (b_bin[i] << 8) | b_cnt[i], (bin << 8) | n);
                chk(b_last[i] == (i == n - 1) && !b_emp[i], "R4", "query last flag",
                    {b_emp[i], b_last[i]}, {1'b0, i == n - 1});
                if (i > 0)
                    chk(b_cyc[i] == b_cyc[i-1] + 1, "R3", "one item per clock",
                        b_cyc[i] - b_cyc[i-1], 1);
            end
        end
    endtask

    task automatic check_dump();
        logic [23:0] e_dat[$];
        int          e_bin[$];
        int          e_cnt[$];
        for (int b = 0; b < NB; b++) begin
            foreach (mq[b][i]) begin
                e_dat.push_back(mq[b][i]);
                e_bin.push_back(b);
                e_cnt.push_back(mq[b].size());
            end
        end
        collect(1'b1, 0);
        if (e_dat.size() == 0) begin
            chk(b_bin.size() == 1, "R6", "empty dump beat count", b_bin.size(), 1);
            if (b_bin.size() == 1)
                chk(b_emp[0] && b_last[0], "R6", "empty dump flags", {b_emp[0], b_last[0]}, 2'b11);
        end else begin
            chk(b_bin.size() == e_dat.size(), "R6", "dump beat count", b_bin.size(), e_dat.size());
            for (int i = 0; i < e_dat.size() && i < b_bin.size(); i++) begin
                chk(b_dat[i] == e_dat[i] && b_bin[i] == e_bin[i] && b_cnt[i] == e_cnt[i],
                    "R6", "dump item/bin/count", {b_bin[i], b_dat[i]}, {e_bin[i], e_dat[i]});
                chk(b_last[i] == (i == e_dat.size() - 1) && !b_emp[i], "R6", "dump last flag",
                    {b_emp[i], b_last[i]}, {1'b0, i == e_dat.size() - 1});
            end
        end
    endtask

    task automatic do_clear();
        int n;
        @(negedge clk);
        clear_req = 1'b1;
        @(negedge clk);
        clear_req = 1'b0;
        n = 1;
        #1;
        chk(!clear_done, "R8", "done low at sweep start", clear_done, 0);
        while (!clear_done && n < 100) begin
            @(negedge clk);
            #1;
            n++;
        end
        chk(n == NB + 1, "R8", "clear_done timing", n, NB + 1);
        @(negedge clk);
        #1;
        chk(!clear_done, "R8", "done is one clock", clear_done, 0);
        chk(!overflow && wr_ready, "R8", "overflow cleared, ready back", {overflow, wr_ready}, 2'b01);
        for (int b = 0; b < NB; b++) mq[b].delete();
        n_stored = 0;
    endtask

    initial begin
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(wr_ready && !out_valid && !overflow && !clear_done, "R10", "reset outputs",
            {wr_ready, out_valid, overflow, clear_done}, 4'b1000);
        check_query(5);                         // R10 / R5: empty after reset
        check_dump();                           // R6: empty store

        // directed: same-bin back-to-back writes (R9), saturation (R1)
        put(12'h3A0, 8'h01, 16'h1111);
        put(12'h3FF, 8'h02, 16'h2222);
        put(12'h300, 8'h03, 16'h3333);
        put(12'hFFF, 8'h04, 16'h4444);          // saturates into bin 15
        put(12'h000, 8'h05, 16'h5555);
        drop();
        chk(mq[3].size() == 3, "R2", "back-to-back writes taken", mq[3].size(), 3);
        check_query(3);
        check_query(15);
        check_query(0);
        check_query(7);
        check_dump();
        check_query(3);                         // R11: nothing added during read-out
        do_clear();
        check_query(3);
        check_dump();

        // random rounds
        for (int r = 0; r < 4; r++) begin
            int nw;
            do_clear();
            nw = 20 + int'($urandom_range(0, 30));
            for (int i = 0; i < nw; i++) begin
                logic [11:0] k;
                k = (i % 3 == 0) ? 12'($urandom_range(12'h200, 12'h4FF)) : 12'(urand_key());
                put(k, 8'($urandom_range(0, 255)), 16'($urandom_range(0, 65535)));
                if ($urandom_range(0, 3) == 0) begin
                    drop();
                    repeat ($urandom_range(0, 2)) @(negedge clk);
                end
            end
            drop();
            for (int q = 0; q < 4; q++) check_query(int'($urandom_range(0, NB - 1)));
            check_dump();
        end

        // fill to capacity (R7)
        do_clear();
        for (int i = 0; i < DEP; i++)
            put(12'(urand_key()), 8'(i), 16'($urandom_range(0, 65535)));
        @(negedge clk);
        wr_valid = 1'b1;
        wr_key = 12'h123;
        #1;
        chk(!wr_ready, "R7", "ready low when full", wr_ready, 0);
        @(negedge clk);
        wr_valid = 1'b0;
        #1;
        chk(overflow, "R7", "overflow set", overflow, 1);
        repeat (3) @(negedge clk);
        #1;
        chk(overflow && !wr_ready, "R7", "overflow sticky, still full", {overflow, wr_ready}, 2'b10);
        chk(n_stored == DEP, "R7", "items accepted", n_stored, DEP);
        check_dump();
        do_clear();
        check_dump();

        finish_run();
    end
endmodule